// File: doc/BRIEF.md
# Quad-data-rate burst SRAM core

This block is a synthesizable behavioural model of a two-port synchronous memory. It has one write data port and one read data port, and both share a single address bus. Every access moves a burst of two 18-bit words. The two words make up one 36-bit stored line: the first word holds bits 17:0 and the second word holds bits 35:18. The model runs from one fast clock. An internal phase tracker marks each edge of that clock as either a positive-clock rise or a negative-clock rise, and these two kinds of edge alternate. The port `k_pos` tells the driving logic which kind of edge comes next. The read address is taken at a positive-clock rise. The write address is taken at the following negative-clock rise. On each port, one 18-bit word moves at every edge.

A write is captured as two half-words. Each half-word carries its own active-low byte mask. The whole line is committed to the array at the negative-clock rise. A read is serialized as two halves on `rdata`, the lower half first. The flag `rvalid` takes the place of three-state outputs: it is high exactly while `rdata` carries read data, and `rdata` is zero at all other times.

Three state machines make up the core:
- Phase tracker: `PH_POS` ↔ `PH_NEG`, toggling on every clock.
- Write capture: `WR_IDLE` → `WR_UPPER` when the write select is low at a positive rise. It returns to `WR_IDLE` at the next edge and commits the line at that point.
- Read serializer: `RD_OFF`/`RD_HIGH` → `RD_LOW` at a positive rise when a read is pending, otherwise → `RD_OFF`. `RD_LOW` → `RD_HIGH` at a negative rise. `RD_OFF`/`RD_HIGH` → `RD_OFF` at a negative rise.

Top module: `qdr_burst_sram`

## Requirements
- R1: During and right after reset, `rvalid` is 0, `rdata` is 0, and `k_pos` is 1, so the first edge after reset release is a positive-clock rise.
- R2: `k_pos` alternates on every clock. A 1 marks the coming edge as a positive-clock rise and a 0 marks it as a negative-clock rise.
- R3: When `rd_sel_n` is 0 at a positive rise, `addr` is captured as the read address. Two edges later, bits 17:0 of that line are on `rdata` with `rvalid` high. One edge after that, bits 35:18 are on `rdata`.
- R4: When `wr_sel_n` is 0 at a positive rise, `wdata` is taken as bits 17:0 of the line. At the next negative rise, `addr` is taken as the write address and `wdata` as bits 35:18, and the line is written into the array at that edge.
- R5: Bit 0 of `wbyte_n` gates data bits 8:0 of the word on the same edge, and bit 1 gates bits 17:9. Both bits are active low. A masked byte keeps its stored value.
- R6: A read and a write may each start at every positive rise. Back-to-back reads give a continuous stream of half-words with `rvalid` held high.
- R7: In every phase that carries no read data, `rvalid` is 0 and `rdata` is 0. This includes the phases after the read port is deselected, once any pending read has finished.
- R8: When a read and a write to the same address start at the same positive rise, the read returns the line with the new write merged in under its byte masks.
- R9: When a write to an address starts at the positive rise after a read of that address, the earlier read returns the line as it was before that write.
- R10: The select inputs have no effect at negative rises. While the write port is deselected, the write data, the masks and the negative-rise address are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock; each edge is one input-clock phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| k_pos | output | 1 | High when the coming edge is a positive-clock rise |
| rd_sel_n | input | 1 | Active-low read start, sampled at positive rises |
| wr_sel_n | input | 1 | Active-low write start, sampled at positive rises |
| addr | input | ADDR_W | Shared address: read at positive rise, write at negative rise |
| wdata | input | WORD_W | Write half-word for the current edge |
| wbyte_n | input | WORD_W/BYTE_W | Active-low byte masks for the current half-word |
| rdata | output | WORD_W | Read half-word; zero when not valid |
| rvalid | output | 1 | High in phases that carry read data |

## Verification
The bench builds the block with its default parameters: a 10-bit address (1024 lines), 18-bit words and 9-bit bytes. It first fills the whole array with known lines, so no read can ever return an unwritten location. In the random phase, addresses are confined to a 16-line window. This makes same-period read/write collisions and reads straight after writes common, which brings the forwarding and ordering rules within reach in every run. Select noise at negative rises and random masks exercise the ignore rules and partial writes against a line model held in the bench.

// File: rtl/qdr_pkg.sv
package qdr_pkg;

    typedef enum logic {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_UPPER = 1'b1
    } wr_state_e;

    typedef enum logic [1:0] {
        RD_OFF  = 2'd0,
        RD_LOW  = 2'd1,
        RD_HIGH = 2'd2
    } rd_state_e;

endpackage

// File: rtl/qdr_phase_track.sv
module qdr_phase_track
    import qdr_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    output phase_e ph
);

    phase_e ph_nx;

    always_comb begin
        unique case (ph)
            PH_POS: ph_nx = PH_NEG;
            PH_NEG: ph_nx = PH_POS;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph <= PH_POS;
        else        ph <= ph_nx;
    end

endmodule

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  phase_e                ph,
    input  logic                  wr_sel_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [WORD_W/BYTE_W-1:0] wbyte_n,
    output logic                  we,
    output logic [ADDR_W-1:0]     waddr,
    output logic [2*WORD_W-1:0]   wline,
    output logic [2*(WORD_W/BYTE_W)-1:0] wbe
);

    localparam int NBYTE = WORD_W / BYTE_W;

    wr_state_e          st, st_nx;
    logic [WORD_W-1:0]  lo_data;
    logic [NBYTE-1:0]   lo_be;

    // next state: a write opens only on a positive rise
    always_comb begin
        st_nx = st;
        unique case (st)
            WR_IDLE:  if (ph == PH_POS && !wr_sel_n) st_nx = WR_UPPER;
            WR_UPPER: st_nx = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= WR_IDLE;
        else        st <= st_nx;
    end

    // lower half-word and its masks held for the negative rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_data <= '0;
            lo_be   <= '0;
        end else if (ph == PH_POS && !wr_sel_n) begin
            lo_data <= wdata;
            lo_be   <= ~wbyte_n;
        end
    end

    // outputs: commit the merged line on the negative rise
    always_comb begin
        we    = 1'b0;
        waddr = addr;
        wline = {wdata, lo_data};
        wbe   = {~wbyte_n, lo_be};
        unique case (st)
            WR_IDLE:  we = 1'b0;
            WR_UPPER: we = (ph == PH_NEG);
        endcase
    end

endmodule

// File: rtl/qdr_line_store.sv
module qdr_line_store #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     waddr,
    input  logic [2*WORD_W-1:0]   wline,
    input  logic [2*(WORD_W/BYTE_W)-1:0] wbe,
    input  logic [ADDR_W-1:0]     raddr,
    output logic [2*WORD_W-1:0]   rline
);

    localparam int DEPTH  = 1 << ADDR_W;
    localparam int LBYTES = 2 * (WORD_W / BYTE_W);

    // one storage lane per byte, so each mask bit owns its own array
    for (genvar b = 0; b < LBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wbe[b]) lane_mem[waddr] <= wline[b*BYTE_W +: BYTE_W];
        end

        assign rline[b*BYTE_W +: BYTE_W] = lane_mem[raddr];
    end

endmodule

// File: rtl/qdr_rd_serializer.sv
module qdr_rd_serializer
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18
) (
    input  logic                clk,
    input  logic                rst_n,
    input  phase_e              ph,
    input  logic                rd_sel_n,
    input  logic [ADDR_W-1:0]   addr,
    output logic [ADDR_W-1:0]   raddr,
    input  logic [2*WORD_W-1:0] rline,
    output logic [WORD_W-1:0]   rdata,
    output logic                rvalid
);

    rd_state_e          st, st_nx;
    logic               pend;
    logic [WORD_W-1:0]  lo_q, hi_q;

    always_comb begin
        st_nx = st;
        if (ph == PH_POS) begin
            unique case (st)
                RD_OFF, RD_LOW, RD_HIGH: st_nx = pend ? RD_LOW : RD_OFF;
                default:                 st_nx = RD_OFF;
            endcase
        end else begin
            unique case (st)
                RD_LOW:  st_nx = RD_HIGH;
                RD_HIGH: st_nx = RD_OFF;
                RD_OFF:  st_nx = RD_OFF;
                default: st_nx = RD_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= RD_OFF;
        else        st <= st_nx;
    end

    // address capture and line fetch, both on positive rises
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend  <= 1'b0;
            raddr <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else if (ph == PH_POS) begin
            pend <= !rd_sel_n;
            if (!rd_sel_n) raddr <= addr;
            if (pend) {hi_q, lo_q} <= rline;
        end
    end

    always_comb begin
        rdata  = '0;
        rvalid = 1'b0;
        unique case (st)
            RD_LOW:  begin rdata = lo_q; rvalid = 1'b1; end
            RD_HIGH: begin rdata = hi_q; rvalid = 1'b1; end
            RD_OFF:  begin rdata = '0;   rvalid = 1'b0; end
            default: begin rdata = '0;   rvalid = 1'b0; end
        endcase
    end

endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram
    import qdr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 18,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    output logic                     k_pos,
    input  logic                     rd_sel_n,
    input  logic                     wr_sel_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [WORD_W-1:0]        wdata,
    input  logic [WORD_W/BYTE_W-1:0] wbyte_n,
    output logic [WORD_W-1:0]        rdata,
    output logic                     rvalid
);

    localparam int NBYTE  = WORD_W / BYTE_W;
    localparam int LINE_W = 2 * WORD_W;
    localparam int LBYTES = 2 * NBYTE;

    phase_e             ph;
    logic               mem_we;
    logic [ADDR_W-1:0]  mem_waddr;
    logic [LINE_W-1:0]  mem_wline;
    logic [LBYTES-1:0]  mem_wbe;
    logic [ADDR_W-1:0]  rd_addr;
    logic [LINE_W-1:0]  rd_line;

    qdr_phase_track u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph    (ph)
    );

    assign k_pos = (ph == PH_POS);

    qdr_wr_capture #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .wbyte_n  (wbyte_n),
        .we       (mem_we),
        .waddr    (mem_waddr),
        .wline    (mem_wline),
        .wbe      (mem_wbe)
    );

    qdr_line_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wline (mem_wline),
        .wbe   (mem_wbe),
        .raddr (rd_addr),
        .rline (rd_line)
    );

    qdr_rd_serializer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph       (ph),
        .rd_sel_n (rd_sel_n),
        .addr     (addr),
        .raddr    (rd_addr),
        .rline    (rd_line),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

endmodule

// File: rtl/qdr_burst_sram_sva.sv
module qdr_burst_sram_sva #(
    parameter int WORD_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              k_pos,
    input logic              rd_sel_n,
    input logic              wr_sel_n,
    input logic              rvalid,
    input logic [WORD_W-1:0] rdata,
    input logic              mem_we
);

    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        seen |-> (k_pos != $past(k_pos)));

    assert_read_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (k_pos && !rd_sel_n) |=> ##2 rvalid);

    assert_burst_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !k_pos) |=> rvalid);

    assert_idle_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (k_pos && rd_sel_n) |=> ##2 !rvalid);

    assert_quiet_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

    assert_commit_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !k_pos);

    assert_commit_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && mem_we) |-> $past(k_pos && !wr_sel_n));

endmodule

bind qdr_burst_sram qdr_burst_sram_sva #(.WORD_W(WORD_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .k_pos    (k_pos),
    .rd_sel_n (rd_sel_n),
    .wr_sel_n (wr_sel_n),
    .rvalid   (rvalid),
    .rdata    (rdata),
    .mem_we   (mem_we)
);

// File: tb/qdr_burst_sram_test.sv
module qdr_burst_sram_test;

    localparam int AW    = 10;
    localparam int WW    = 18;
    localparam int LW    = 36;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          k_pos;
    logic          rd_sel_n;
    logic          wr_sel_n;
    logic [AW-1:0] addr;
    logic [WW-1:0] wdata;
    logic [1:0]    wbyte_n;
    logic [WW-1:0] rdata;
    logic          rvalid;

    always #5 clk = ~clk;

    qdr_burst_sram uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .k_pos    (k_pos),
        .rd_sel_n (rd_sel_n),
        .wr_sel_n (wr_sel_n),
        .addr     (addr),
        .wdata    (wdata),
        .wbyte_n  (wbyte_n),
        .rdata    (rdata),
        .rvalid   (rvalid)
    );

    logic [LW-1:0] model [DEPTH];
    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;

    // expected read slots: 1 = lower half due next, 2 = upper half due next
    logic          v1 = 1'b0, v2 = 1'b0;
    logic [LW-1:0] l1 = '0,   l2 = '0;
    string         t1 = "R7", t2 = "R7";

    task automatic check_eq(string tag, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // byte-masked merge of a two-half write into a stored line (masks active low)
    function automatic logic [LW-1:0] merge(logic [LW-1:0] old, logic [WW-1:0] d0, logic [1:0] m0,
                                           logic [WW-1:0] d1, logic [1:0] m1);
        logic [LW-1:0] r = old;
        if (!m0[0]) r[8:0]   = d0[8:0];
        if (!m0[1]) r[17:9]  = d0[17:9];
        if (!m1[0]) r[26:18] = d1[8:0];
        if (!m1[1]) r[35:27] = d1[17:9];
        return r;
    endfunction

    // one positive/negative period; starts and ends just after a negative clk edge
    task automatic period(bit rd, logic [AW-1:0] ra, bit wr, logic [AW-1:0] wa,
                          logic [WW-1:0] d0, logic [1:0] m0, logic [WW-1:0] d1, logic [1:0] m1,
                          bit noise, string tag);
        check_eq("R2", "k_pos before positive rise", {35'd0, k_pos}, 36'd1);
        check_eq(v2 ? t2 : "R7", "upper valid", {35'd0, rvalid}, {35'd0, v2});
        check_eq(v2 ? t2 : "R7", "upper data", {18'd0, rdata}, v2 ? {18'd0, l2[35:18]} : '0);
        rd_sel_n = !rd;
        wr_sel_n = !wr;
        addr     = rd ? ra : AW'($urandom);
        wdata    = wr ? d0 : WW'($urandom);
        wbyte_n  = wr ? m0 : 2'($urandom);
        @(posedge clk);
        @(negedge clk);
        check_eq("R2", "k_pos before negative rise", {35'd0, k_pos}, 36'd0);
        check_eq(v1 ? t1 : "R7", "lower valid", {35'd0, rvalid}, {35'd0, v1});
        check_eq(v1 ? t1 : "R7", "lower data", {18'd0, rdata}, v1 ? {18'd0, l1[17:0]} : '0);
        rd_sel_n = noise ? 1'($urandom) : 1'b1;
        wr_sel_n = noise ? 1'($urandom) : 1'b1;
        addr     = wr ? wa : AW'($urandom);
        wdata    = wr ? d1 : WW'($urandom);
        wbyte_n  = wr ? m1 : 2'($urandom);
        @(posedge clk);
        @(negedge clk);
        if (wr) model[wa] = merge(model[wa], d0, m0, d1, m1);
        v2 = v1; l2 = l1; t2 = t1;
        v1 = rd;
        l1 = rd ? model[ra] : '0;
        t1 = rd ? tag : "R7";
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst_n    = 1'b0;
        rd_sel_n = 1'b1;
        wr_sel_n = 1'b1;
        addr     = '0;
        wdata    = '0;
        wbyte_n  = 2'b11;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_eq("R1", "rvalid in reset", {35'd0, rvalid}, '0);
        check_eq("R1", "rdata in reset", {18'd0, rdata}, '0);
        check_eq("R1", "k_pos in reset", {35'd0, k_pos}, 36'd1);
        rst_n = 1'b1;

        // R4: fill every line with full-mask writes
        for (int a = 0; a < DEPTH; a++)
            period(0, '0, 1, AW'(a), WW'($urandom), 2'b00, WW'($urandom), 2'b00, 0, "R4");

        // R4/R3: read back, including a line stored at the top address
        period(1, 10'd3, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R4");
        period(1, 10'd1023, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R3");
        period(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R7");
        period(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R7");

        // R5: partial write, then read
        period(0, '0, 1, 10'd7, 18'h2AAAA, 2'b01, 18'h15555, 2'b10, 0, "R5");
        period(1, 10'd7, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R5");
        period(0, '0, 1, 10'd8, 18'h3FFFF, 2'b11, 18'h3FFFF, 2'b11, 0, "R5");
        period(1, 10'd8, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R5");

        // R8: same-address read and write in one period
        period(1, 10'd20, 1, 10'd20, 18'h12345, 2'b00, 18'h0BEEF, 2'b00, 0, "R8");
        period(1, 10'd21, 1, 10'd21, 18'h00F0F, 2'b10, 18'h3C3C3, 2'b01, 0, "R8");

        // R9: write in the period right after a read of the same address
        period(1, 10'd30, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R9");
        period(0, '0, 1, 10'd30, 18'h1CAFE, 2'b00, 18'h0FACE, 2'b00, 0, "R9");
        period(1, 10'd30, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R9");

        // R10: deselected write port with select noise at negative rises
        for (int i = 0; i < 6; i++)
            period(0, '0, 0, 10'd40, '0, 2'b00, '0, 2'b00, 1, "R10");
        period(1, 10'd40, 0, '0, '0, 2'b11, '0, 2'b11, 1, "R10");

        // R7: deselect after a read; pending burst completes then goes quiet
        period(1, 10'd41, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R7");
        for (int i = 0; i < 3; i++)
            period(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R7");

        // R6: random back-to-back traffic in a small address window
        for (int i = 0; i < 3000; i++)
            period(($urandom % 4) != 0, AW'($urandom % 16), 1'($urandom), AW'($urandom % 16),
                   WW'($urandom), 2'($urandom), WW'($urandom), 2'($urandom), 1, "R6");
        for (int i = 0; i < 3; i++)
            period(0, '0, 0, '0, '0, 2'b11, '0, 2'b11, 0, "R7");

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule